// File: doc/BRIEF.md
# Load/Store Address Overlap Matrix

This block keeps a small table of outstanding memory accesses and reports, for every pair of them, whether the two might touch a common byte. Each table slot holds a valid flag, an address and an access size of 1, 2, 4 or 8 bytes. Upstream logic writes slots one at a time through a write port. Downstream ordering logic reads an N-by-N hazard matrix and a per-slot byte-enable map.

The match is deliberately conservative. The block does not compare full addresses. It compares an 8-bit slice of the address just above the 16-byte line offset. Inside the line, it compares unary byte maps built from the size and the offset. These maps are 24 bits wide, so an access that runs past the end of its line shows up as spill bits. The spill bits are matched against the start of the next line. Pairs whose upper address bits differ can alias and be flagged, which is harmless. A pair that truly shares a byte is always flagged.

The write port uses valid/ready. Ready is low while reset is asserted and high from the first clock after reset is released. After that the port never applies back-pressure. A beat is taken on any rising edge where both valid and ready are high. The matrix and the maps are combinational from the registered table, so they reflect a write from the edge that takes it.

Top module: `lsovl_matrix`

## Requirements
- R1: While reset is asserted, and right after it, every slot is invalid, the whole matrix is 0 and every byte map is 0. wr_ready is 0 during reset and 1 from the first rising edge after reset is released.
- R2: A beat with wr_valid and wr_ready high loads slot wr_idx at that edge. wr_keep=1 makes the slot valid with wr_addr and wr_len. wr_keep=0 makes it invalid. All other slots are unchanged.
- R3: The size code wr_len encodes 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. The byte map of a valid slot is (2^bytes - 1) shifted left by addr[3:0]. It is 24 bits wide, and bit 23 is never set.
- R4: An invalid slot shows a byte map of 0. Its row and column of the matrix are all 0.
- R5: Matrix bit i*ENTRIES+i (the diagonal) is always 0.
- R6: The matrix is symmetric: bit i*ENTRIES+j equals bit j*ENTRIES+i.
- R7: Two valid slots with equal line slices addr[11:4] overlap when the AND of their map bits [15:0] is non-zero.
- R8: Two valid slots also overlap when slice(a)+1 modulo 256 equals slice(b), and map(a)[23:16] AND map(b)[7:0] is non-zero.
- R9: In every other case the bit is 0. Address bits above bit 11 never affect the result, so slots that differ only there can alias.
- R10: Any two valid slots whose byte ranges [addr, addr+bytes) truly intersect are always flagged.
- R11: The matrix and the maps follow a write at the same edge that takes it, with no extra pipeline cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat can be taken |
| wr_idx | input | IDX_W | Slot to write |
| wr_addr | input | ADDR_W | Access byte address |
| wr_len | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| wr_keep | input | 1 | 1 fills the slot, 0 frees it |
| ovl_matrix | output | ENTRIES*ENTRIES | Bit i*ENTRIES+j flags a hazard between slots i and j |
| ent_mask | output | ENTRIES*24 | Bits [i*24 +: 24] hold the byte map of slot i |

## Verification
The assertions assume that wr_idx is below ENTRIES whenever a beat is offered. They also assume that wr_len is one of the four legal codes. The stimulus draws indices only from the table range and sizes only from those codes. Addresses are drawn from narrow clusters so that same-line, next-line and aliasing pairs occur often. Some clusters sit near the top of the address space, so the slice wraps modulo 256. The bench checks the matrix against the exact slice-and-map rule. It separately checks that no real byte intersection is ever left unflagged.

// File: rtl/lsovl_pkg.sv
package lsovl_pkg;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } size_code_e;

  localparam int MAX_BYTES = 8;

  // unary byte run for a size code, right-aligned
  function automatic logic [MAX_BYTES-1:0] size_run(input logic [1:0] code);
    logic [MAX_BYTES-1:0] r;
    case (size_code_e'(code))
      SZ_B1:   r = 8'h01;
      SZ_B2:   r = 8'h03;
      SZ_B4:   r = 8'h0F;
      default: r = 8'hFF;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsovl_entry_table.sv
module lsovl_entry_table #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_fire,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [1:0]                      wr_len,
  input  logic                            wr_keep,
  output logic [ENTRIES-1:0]              ent_valid,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  ent_addr,
  output logic [ENTRIES-1:0][1:0]         ent_len
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic hit;
    assign hit = wr_fire && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[e] <= 1'b0;
        ent_addr[e]  <= '0;
        ent_len[e]   <= 2'd0;
      end else if (hit) begin
        ent_valid[e] <= wr_keep;
        ent_addr[e]  <= wr_addr;
        ent_len[e]   <= wr_len;
      end
    end
  end

endmodule

// File: rtl/lsovl_mask_gen.sv
module lsovl_mask_gen #(
  parameter int OFF_W  = 4,
  parameter int SPAN_W = 24
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        len,
  output logic [SPAN_W-1:0] span
);
  import lsovl_pkg::*;

  logic [SPAN_W-1:0] run;

  always_comb begin
    run  = SPAN_W'(size_run(len));
    span = run << offset;
  end

endmodule

// File: rtl/lsovl_pair_cmp.sv
module lsovl_pair_cmp #(
  parameter int SLICE_W    = 8,
  parameter int LINE_BYTES = 16,
  parameter int SPAN_W     = 24
) (
  input  logic               va,
  input  logic               vb,
  input  logic [SLICE_W-1:0] slice_a,
  input  logic [SLICE_W-1:0] slice_b,
  input  logic [SPAN_W-1:0]  span_a,
  input  logic [SPAN_W-1:0]  span_b,
  output logic               hit
);
  localparam int SPILL_W = SPAN_W - LINE_BYTES;

  logic [SLICE_W-1:0] next_a, next_b;
  logic               same_line, a_into_b, b_into_a;

  always_comb begin
    next_a    = slice_a + SLICE_W'(1);
    next_b    = slice_b + SLICE_W'(1);
    same_line = (slice_a == slice_b) &&
                (|(span_a[LINE_BYTES-1:0] & span_b[LINE_BYTES-1:0]));
    a_into_b  = (next_a == slice_b) &&
                (|(span_a[SPAN_W-1:LINE_BYTES] & span_b[SPILL_W-1:0]));
    b_into_a  = (next_b == slice_a) &&
                (|(span_b[SPAN_W-1:LINE_BYTES] & span_a[SPILL_W-1:0]));
    hit       = va && vb && (same_line || a_into_b || b_into_a);
  end

endmodule

// File: rtl/lsovl_matrix.sv
module lsovl_matrix #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 4,
  parameter int SLICE_W = 8,
  localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int LINE_BYTES = 1 << OFF_W,
  localparam int SPAN_W     = LINE_BYTES + lsovl_pkg::MAX_BYTES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [1:0]                  wr_len,
  input  logic                        wr_keep,
  output logic [ENTRIES*ENTRIES-1:0]  ovl_matrix,
  output logic [ENTRIES*SPAN_W-1:0]   ent_mask
);

  logic                            rdy_q;
  logic                            wr_fire;
  logic [ENTRIES-1:0]              ent_valid;
  logic [ENTRIES-1:0][ADDR_W-1:0]  ent_addr;
  logic [ENTRIES-1:0][1:0]         ent_len;
  logic [ENTRIES-1:0][SPAN_W-1:0]  span;
  logic [ENTRIES-1:0][SLICE_W-1:0] slice;
  logic [ENTRIES-1:0][ENTRIES-1:0] pair_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign wr_ready = rdy_q;
  assign wr_fire  = wr_valid && rdy_q;

  lsovl_entry_table #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(wr_idx),
    .wr_addr(wr_addr), .wr_len(wr_len), .wr_keep(wr_keep),
    .ent_valid(ent_valid), .ent_addr(ent_addr), .ent_len(ent_len)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    lsovl_mask_gen #(.OFF_W(OFF_W), .SPAN_W(SPAN_W)) u_mask (
      .offset(ent_addr[e][OFF_W-1:0]),
      .len(ent_len[e]),
      .span(span[e])
    );
    assign slice[e] = ent_addr[e][OFF_W +: SLICE_W];
    assign ent_mask[e*SPAN_W +: SPAN_W] = ent_valid[e] ? span[e] : '0;
  end

  // triangular compare, mirrored below the diagonal
  for (genvar i = 0; i < ENTRIES; i++) begin : g_row
    for (genvar j = 0; j < ENTRIES; j++) begin : g_col
      if (i < j) begin : g_upper
        lsovl_pair_cmp #(
          .SLICE_W(SLICE_W), .LINE_BYTES(LINE_BYTES), .SPAN_W(SPAN_W)
        ) u_cmp (
          .va(ent_valid[i]), .vb(ent_valid[j]),
          .slice_a(slice[i]), .slice_b(slice[j]),
          .span_a(span[i]), .span_b(span[j]),
          .hit(pair_hit[i][j])
        );
      end else begin : g_none
        assign pair_hit[i][j] = 1'b0;
      end
      if (i < j) begin : g_out_u
        assign ovl_matrix[i*ENTRIES+j] = pair_hit[i][j];
      end else if (i > j) begin : g_out_l
        assign ovl_matrix[i*ENTRIES+j] = pair_hit[j][i];
      end else begin : g_out_d
        assign ovl_matrix[i*ENTRIES+j] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lsovl_matrix_chk.sv
module lsovl_matrix_chk #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int SPAN_W  = 24
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_valid,
  input logic                       wr_ready,
  input logic [IDX_W-1:0]           wr_idx,
  input logic                       wr_keep,
  input logic [ENTRIES-1:0]         ent_valid,
  input logic [ENTRIES*ENTRIES-1:0] ovl_matrix,
  input logic [ENTRIES*SPAN_W-1:0]  ent_mask
);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (ovl_matrix == '0 && ent_mask == '0 && !wr_ready); // R1
    end
  end

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_ready); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (int'(wr_idx) < ENTRIES))
      |=> (ent_valid[$past(wr_idx)] == $past(wr_keep))); // R2

  for (genvar i = 0; i < ENTRIES; i++) begin : g_i
    AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_mask[i*SPAN_W + SPAN_W - 1]); // R3

    AST_MAP_RUN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[i] |-> ($countones(ent_mask[i*SPAN_W +: SPAN_W]) inside {1, 2, 4, 8})); // R3

    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_valid[i] |-> (ovl_matrix[i*ENTRIES +: ENTRIES] == '0 &&
                         ent_mask[i*SPAN_W +: SPAN_W] == '0)); // R4

    AST_DIAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_matrix[i*ENTRIES+i]); // R5

    for (genvar j = i + 1; j < ENTRIES; j++) begin : g_j
      AST_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_matrix[i*ENTRIES+j] == ovl_matrix[j*ENTRIES+i]); // R6
    end
  end

endmodule

bind lsovl_matrix lsovl_matrix_chk #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .SPAN_W(SPAN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_idx(wr_idx), .wr_keep(wr_keep), .ent_valid(ent_valid),
  .ovl_matrix(ovl_matrix), .ent_mask(ent_mask)
);

// File: tb/sim_lsovl_matrix.sv
`timescale 1ns/1ps
module sim_lsovl_matrix;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int SW = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_valid = 1'b0;
  logic           wr_ready;
  logic [2:0]     wr_idx = '0;
  logic [AW-1:0]  wr_addr = '0;
  logic [1:0]     wr_len = '0;
  logic           wr_keep = 1'b0;
  logic [N*N-1:0] ovl_matrix;
  logic [N*SW-1:0] ent_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsovl_matrix u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_len(wr_len), .wr_keep(wr_keep),
    .ovl_matrix(ovl_matrix), .ent_mask(ent_mask)
  );

  // behavioural reference state
  bit      m_valid [N];
  longint  m_addr  [N];
  int      m_bytes [N];
  bit      m_rdy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy <= 1'b0;
      for (int k = 0; k < N; k++) begin
        m_valid[k] <= 1'b0; m_addr[k] <= 0; m_bytes[k] <= 1;
      end
    end else begin
      m_rdy <= 1'b1;
      if (wr_valid && m_rdy) begin
        m_valid[wr_idx] <= wr_keep;
        m_addr[wr_idx]  <= longint'(wr_addr);
        m_bytes[wr_idx] <= 1 << wr_len;
      end
    end
  end

  function automatic longint exp_map(int k);
    if (!m_valid[k]) return 0;
    return ((longint'(1) << m_bytes[k]) - 1) << (m_addr[k] % 16);
  endfunction

  function automatic bit rule_hit(int a, int b);
    longint ma, mb;
    int sa, sb;
    if (a == b || !m_valid[a] || !m_valid[b]) return 0;
    ma = exp_map(a); mb = exp_map(b);
    sa = int'((m_addr[a] / 16) % 256);
    sb = int'((m_addr[b] / 16) % 256);
    if (sa == sb && ((ma & mb & 'hFFFF) != 0)) return 1;
    if ((sa + 1) % 256 == sb && (((ma >> 16) & mb & 'hFF) != 0)) return 1;
    if ((sb + 1) % 256 == sa && (((mb >> 16) & ma & 'hFF) != 0)) return 1;
    return 0;
  endfunction

  function automatic bit true_hit(int a, int b);
    if (a == b || !m_valid[a] || !m_valid[b]) return 0;
    return (m_addr[a] < m_addr[b] + m_bytes[b]) && (m_addr[b] < m_addr[a] + m_bytes[a]);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // compare against the reference on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 wr_ready", longint'(wr_ready), longint'(m_rdy));
      for (int i = 0; i < N; i++) begin
        check($sformatf("R3/R4 map slot %0d", i),
              longint'(ent_mask[i*SW +: SW]), exp_map(i));
        check($sformatf("R5 diag %0d", i), longint'(ovl_matrix[i*N+i]), 0);
        for (int j = 0; j < N; j++) begin
          if (i != j) begin
            check($sformatf("R7/R8/R9 pair %0d,%0d", i, j),
                  longint'(ovl_matrix[i*N+j]), longint'(rule_hit(i, j)));
            check($sformatf("R6 mirror %0d,%0d", i, j),
                  longint'(ovl_matrix[i*N+j]), longint'(ovl_matrix[j*N+i]));
            if (true_hit(i, j))
              check($sformatf("R10 real overlap %0d,%0d", i, j),
                    longint'(ovl_matrix[i*N+j]), 1);
          end
        end
      end
    end
  end

  task automatic put(int idx, longint addr, int len, bit keep);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 3'(idx); wr_addr = AW'(addr);
    wr_len = 2'(len); wr_keep = keep;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    check("R1 reset ready", longint'(wr_ready), 0);
    check("R1 reset matrix", longint'(ovl_matrix != 0), 0);
    check("R1 reset maps", longint'(ent_mask != 0), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", longint'(wr_ready), 1);
    check("R1 table empty", longint'(ovl_matrix != 0), 0);

    // R11: the write lands at the edge between put's two negedges
    put(0, 'h100, 3, 1);
    check("R11 map same edge", longint'(ent_mask[0 +: SW]), 'hFF);
    put(1, 'h104, 2, 1);
    check("R7 same line overlap", longint'(ovl_matrix[0*N+1]), 1);
    put(2, 'h10F, 3, 1);
    check("R3 spill map", longint'(ent_mask[2*SW +: SW]), 'h7F8000);
    put(3, 'h112, 1, 1);
    check("R8 spill overlap", longint'(ovl_matrix[2*N+3]), 1);
    check("R8 no same-line hit", longint'(ovl_matrix[0*N+3]), 0);
    put(4, 'h1100, 0, 1);
    check("R9 upper bits alias", longint'(ovl_matrix[0*N+4]), 1);
    put(5, 'h120, 2, 1);
    check("R9 disjoint line", longint'(ovl_matrix[0*N+5]), 0);
    put(6, 'h108, 0, 1);
    check("R7 disjoint bytes", longint'(ovl_matrix[1*N+6]), 0);
    put(0, 'h100, 3, 0);
    check("R2 freed slot row", longint'(ovl_matrix[0*N +: N]), 0);
    check("R4 freed slot map", longint'(ent_mask[0 +: SW]), 0);
    check("R2 other slot kept", longint'(ent_mask[1*SW +: SW]), 'hF0);
    put(7, 'hFFFFFFFF, 1, 1);
    put(6, 'h0, 0, 1);
    check("R8 slice wrap alias", longint'(ovl_matrix[7*N+6]), 1);

    // clustered random traffic
    for (int n = 0; n < 3000; n++) begin
      longint base;
      case ($urandom % 3)
        0: base = 'h1000;
        1: base = 'hFFFFFF80;
        default: base = 'h21000;
      endcase
      put(int'($urandom % N), base + longint'($urandom % 96),
          int'($urandom % 4), ($urandom % 5) != 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule